// File: doc/BRIEF.md
# Password-Locked Configuration Register File

This block is the register file of a timekeeping peripheral, reached through a plain byte-wide bus: an address, a write data byte, a write strobe and a combinational read data byte. It holds a bank of time registers, a control byte, a RAM mirror of the nonvolatile configuration bytes, and a model of the nonvolatile array itself. The mirror is normally refreshed from the array at a fixed interval. Software can stop this refresh, edit the mirror, and then make the edits persistent by writing an update command. The command keeps a busy flag high for a fixed number of cycles.

Write protection applies only when the protection-arm configuration byte holds 255. While protection is armed and the block is locked, the bus can still read the time and control registers. It cannot write them, and it can neither read nor write the configuration mirror. Writing a four-byte password unlocks the block when the password equals the reference word held in the mirror. Writing a password that differs locks the block again. The nonvolatile model is a bank of flops that is copied on command. It is preset from a parameter at reset.

Top module: `cfg_lock_regfile`

## Requirements
- R1: After reset the time registers (00h to 0Fh), the control byte (10h) and the command/status byte (3Fh) read 00h, the configuration mirror (C0h to CAh) holds the preset array contents, and the block is locked.
- R2: While protection is armed and the block is locked, writes to the time registers and the control byte are ignored, and those registers still read back their stored values.
- R3: While protection is armed and the block is locked, every mirror address reads 00h, mirror writes are ignored, and an update command does not start.
- R4: The password bytes are written at 39h, 3Ah, 3Bh and 3Ch, and they are compared with C6h, C7h, C8h and C9h in that order. The comparison takes place when 3Ch is written. On a match the block unlocks.
- R5: Writing 3Ch so that the four-byte password differs from the reference locks the block again.
- R6: When the byte at CAh is anything other than FFh, all registers can be written and read whatever the lock state.
- R7: The password addresses 39h to 3Ch always read 00h.
- R8: While bit 2 of the control byte is 0, the mirror is reloaded from the nonvolatile array at least once every REFRESH_CYCLES cycles, and unsaved mirror edits are discarded.
- R9: While bit 2 of the control byte is 1, the mirror keeps bus edits with no refresh.
- R10: Writing 11h to 3Fh sets bit 0 of 3Fh (busy) from the next cycle for exactly BUSY_CYCLES cycles. When busy clears, the array holds the mirror contents.
- R11: A value other than 11h written to 3Fh starts nothing. A command written while busy is high neither restarts nor extends the busy period.
- R12: When 13h is written to C0h and then made persistent by the update command, C0h reads 13h after the mirror refreshes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data byte |
| we | input | 1 | Write strobe, sampled on the rising edge |
| rdata | output | 8 | Combinational read data for `addr` |

## Verification
Reads have no latency: the bench presents an address just after a rising edge and compares `rdata` at the following falling edge. It therefore sees the state left by the previous edge. Written values, lock changes and the start of busy all appear one edge after the write. Busy falls exactly BUSY_CYCLES edges after the command edge. The bench samples the last busy cycle and the first idle cycle, with the count taken from the command edge and not from the end of the write task. A mirror refresh can arrive at any phase of its free-running interval, so the checks that depend on a refresh wait REFRESH_CYCLES plus a small margin and do not look for one exact edge.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
   // Fixed register map locations that software sequences depend on
   localparam logic [7:0] ADR_CTRL   = 8'h10;
   localparam logic [7:0] ADR_PW0    = 8'h39;
   localparam logic [7:0] ADR_CMD    = 8'h3F;
   localparam logic [7:0] ADR_CFG    = 8'hC0;
   // Command and arming codes
   localparam logic [7:0] CMD_UPDATE = 8'h11;
   localparam logic [7:0] PROT_ARM   = 8'hFF;
   // Offsets inside the configuration mirror
   localparam int REF_OFS    = 6;   // C6h..C9h reference password
   localparam int PROT_OFS   = 10;  // CAh protection arm byte
   localparam int RFDIS_BIT  = 2;   // control byte refresh-disable bit
   localparam int MIN_CFG    = 11;
endpackage

// File: rtl/cfg_pw_lock.sv
module cfg_pw_lock
   import cfg_lock_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        pw_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [4*DATA_W-1:0] ref_word,
   output logic              locked
);
   logic [2:0][DATA_W-1:0] pw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pw_q   <= '0;
         locked <= 1'b1;
      end else begin
         for (int k = 0; k < 3; k++) begin
            if (pw_we[k]) pw_q[k] <= wdata;
         end
         // Final byte triggers the compare against the stored reference
         if (pw_we[3]) locked <= ({pw_q[0], pw_q[1], pw_q[2], wdata} != ref_word);
      end
   end

   // Lock state moves only on a write of the final password byte
   assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pw_we[3] |=> $stable(locked));
endmodule

// File: rtl/cfg_refresh_timer.sv
module cfg_refresh_timer #(
   parameter int REFRESH_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic reload
);
   localparam int TW = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
   localparam logic [TW-1:0] TOP = TW'(REFRESH_CYCLES - 1);

   logic [TW-1:0] cnt_q;
   logic          tick;

   assign tick   = (cnt_q == '0);
   assign reload = tick & ~hold;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= TOP;
      else if (tick) cnt_q <= TOP;
      else           cnt_q <= cnt_q - TW'(1);
   end

   // Reloads are spaced by the full interval, never back to back
   assert_reload_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> !reload);
endmodule

// File: rtl/cfg_update_seq.sv
module cfg_update_seq #(
   parameter int BUSY_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy,
   output logic commit
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign commit = busy & (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (!busy) begin
         if (req) begin
            busy  <= 1'b1;
            cnt_q <= LOAD;
         end
      end else if (cnt_q == '0) begin
         busy <= 1'b0;
      end else begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !commit) |=> busy);
   assert_commit_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !busy);
   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req && !commit) |=> (busy && cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/cfg_nv_bank.sv
module cfg_nv_bank #(
   parameter int CFG_BYTES = 11,
   parameter int DATA_W    = 8,
   parameter logic [CFG_BYTES*DATA_W-1:0] NV_INIT = '0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               commit,
   input  logic                               reload,
   input  logic [CFG_BYTES-1:0]               byte_we,
   input  logic [DATA_W-1:0]                  wdata,
   output logic [CFG_BYTES-1:0][DATA_W-1:0]   mirror
);
   logic [CFG_BYTES-1:0][DATA_W-1:0] nv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CFG_BYTES; i++) begin
            nv_q[i]   <= NV_INIT[i*DATA_W +: DATA_W];
            mirror[i] <= NV_INIT[i*DATA_W +: DATA_W];
         end
      end else begin
         if (commit) nv_q <= mirror;
         for (int i = 0; i < CFG_BYTES; i++) begin
            if (byte_we[i])  mirror[i] <= wdata;
            else if (reload) mirror[i] <= nv_q[i];
         end
      end
   end

   // The persistent store changes only at the end of an update
   assert_nv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(nv_q));
endmodule

// File: rtl/cfg_lock_regfile.sv
module cfg_lock_regfile
   import cfg_lock_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 8,
   parameter int NUM_TIME_REGS  = 16,
   parameter int CFG_BYTES      = 11,
   parameter int REFRESH_CYCLES = 64,
   parameter int BUSY_CYCLES    = 8,
   parameter logic [CFG_BYTES*DATA_W-1:0] NV_INIT =
      {8'hFF, 8'h57, 8'h50, 8'h45, 8'h45, 48'h0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] rdata
);
   // Elaboration-time parameter checks
   if (ADDR_W != 8 || DATA_W != 8) begin : g_bad_width
      $error("cfg_lock_regfile: bus must be 8-bit address and 8-bit data");
   end
   if (NUM_TIME_REGS < 1 || NUM_TIME_REGS > 16) begin : g_bad_time
      $error("cfg_lock_regfile: time bank must fit below the control byte");
   end
   if (CFG_BYTES < MIN_CFG || CFG_BYTES > 64) begin : g_bad_cfg
      $error("cfg_lock_regfile: mirror must reach the protection arm byte");
   end
   if (REFRESH_CYCLES < 2 || BUSY_CYCLES < 1) begin : g_bad_timing
      $error("cfg_lock_regfile: refresh interval >= 2 and busy period >= 1");
   end

   logic [NUM_TIME_REGS-1:0][DATA_W-1:0] time_q;
   logic [DATA_W-1:0]                    ctrl_q;
   logic [CFG_BYTES-1:0][DATA_W-1:0]     mirror;
   logic [NUM_TIME_REGS-1:0]             time_we;
   logic [CFG_BYTES-1:0]                 cfg_we;
   logic [3:0]                           pw_we;
   logic [4*DATA_W-1:0]                  ref_word;
   logic locked, prot_on, lk, wr_ok, ctrl_we;
   logic busy, commit, reload, cmd_req, refresh_off;

   assign prot_on     = (mirror[PROT_OFS] == PROT_ARM);
   assign lk          = prot_on & locked;
   assign wr_ok       = we & ~lk;
   assign ctrl_we     = wr_ok && (addr == ADR_CTRL);
   assign cmd_req     = wr_ok && (addr == ADR_CMD) && (wdata == CMD_UPDATE);
   assign refresh_off = ctrl_q[RFDIS_BIT];
   assign ref_word    = {mirror[REF_OFS], mirror[REF_OFS+1],
                         mirror[REF_OFS+2], mirror[REF_OFS+3]};

   // Per-register write decode
   for (genvar i = 0; i < NUM_TIME_REGS; i++) begin : g_time_dec
      assign time_we[i] = wr_ok && (addr == ADDR_W'(i));
   end
   for (genvar i = 0; i < CFG_BYTES; i++) begin : g_cfg_dec
      assign cfg_we[i] = wr_ok && (addr == ADR_CFG + ADDR_W'(i));
   end
   for (genvar k = 0; k < 4; k++) begin : g_pw_dec
      assign pw_we[k] = we && (addr == ADR_PW0 + ADDR_W'(k));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
         ctrl_q <= '0;
      end else begin
         for (int i = 0; i < NUM_TIME_REGS; i++) begin
            if (time_we[i]) time_q[i] <= wdata;
         end
         if (ctrl_we) ctrl_q <= wdata;
      end
   end

   cfg_pw_lock #(.DATA_W(DATA_W)) u_lock (
      .clk(clk), .rst_n(rst_n), .pw_we(pw_we), .wdata(wdata),
      .ref_word(ref_word), .locked(locked));

   cfg_update_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(cmd_req), .busy(busy), .commit(commit));

   cfg_refresh_timer #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .hold(refresh_off | busy), .reload(reload));

   cfg_nv_bank #(.CFG_BYTES(CFG_BYTES), .DATA_W(DATA_W), .NV_INIT(NV_INIT)) u_nv (
      .clk(clk), .rst_n(rst_n), .commit(commit), .reload(reload),
      .byte_we(cfg_we), .wdata(wdata), .mirror(mirror));

   // Read multiplexer; password bytes and unmapped addresses read zero
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_TIME_REGS; i++) begin
         if (addr == ADDR_W'(i)) rdata = time_q[i];
      end
      if (addr == ADR_CTRL) rdata = ctrl_q;
      if (addr == ADR_CMD)  rdata = {{(DATA_W-1){1'b0}}, busy};
      for (int i = 0; i < CFG_BYTES; i++) begin
         if (addr == ADR_CFG + ADDR_W'(i)) rdata = lk ? '0 : mirror[i];
      end
   end

   assert_locked_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lk) |=> ($stable(time_q) && $stable(ctrl_q)));
   assert_locked_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk && !busy) |=> !busy);
   assert_locked_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lk && !reload) |=> $stable(mirror));
   assert_rfdis_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_off && cfg_we == '0) |=> $stable(mirror));
endmodule

// File: tb/cfg_lock_regfile_bench.sv
module cfg_lock_regfile_bench;
   localparam int REF  = 64;
   localparam int BUSY = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       we = 1'b0;
   logic [7:0] rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] a;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   cfg_lock_regfile #(.REFRESH_CYCLES(REF), .BUSY_CYCLES(BUSY)) u_cfg_lock_regfile (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata));

   // Monitor: compares queued expectations half a cycle after the address
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (rdata !== it.exp || addr !== it.a) begin
            errors++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h",
                     it.tag, it.a, rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      addr = a; we = 1'b0;
      it.a = a; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic unlock();
      wr(8'h39, 8'h45); wr(8'h3A, 8'h45); wr(8'h3B, 8'h50); wr(8'h3C, 8'h57);
   endtask

   task automatic wait_refresh();
      repeat (REF + 4) @(posedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(8'h00, 8'h00, "R1 time reg");
      rd(8'h10, 8'h00, "R1 control");
      rd(8'h3F, 8'h00, "R1 busy idle");
      // R2 locked writes ignored
      wr(8'h05, 8'h5A);
      rd(8'h05, 8'h00, "R2 locked time write");
      wr(8'h10, 8'h04);
      rd(8'h10, 8'h00, "R2 locked control write");
      // R3 mirror hidden and command blocked
      rd(8'hCA, 8'h00, "R3 locked mirror read");
      wr(8'hC0, 8'h13);
      wr(8'h3F, 8'h11);
      rd(8'h3F, 8'h00, "R3 locked command");
      // R7 password reads zero
      wr(8'h39, 8'h45);
      rd(8'h39, 8'h00, "R7 password readback");
      // R4 unlock with matching password
      unlock();
      rd(8'h3C, 8'h00, "R7 last password byte");
      rd(8'hC6, 8'h45, "R1 reference byte C6");
      rd(8'hC9, 8'h57, "R1 reference byte C9");
      rd(8'hCA, 8'hFF, "R1 arm byte");
      rd(8'hC0, 8'h00, "R3 locked C0 write ignored");
      wr(8'h05, 8'h5A);
      rd(8'h05, 8'h5A, "R4 unlocked time write");
      // R5 mismatch relocks
      wr(8'h3C, 8'h00);
      rd(8'h05, 8'h5A, "R2 locked still readable");
      rd(8'hC6, 8'h00, "R5 relocked mirror");
      wr(8'h05, 8'h11);
      rd(8'h05, 8'h5A, "R5 relocked write");
      // R4 reversed byte values do not unlock
      wr(8'h39, 8'h57); wr(8'h3A, 8'h50); wr(8'h3B, 8'h45); wr(8'h3C, 8'h45);
      rd(8'hC6, 8'h00, "R4 wrong order stays locked");
      unlock();
      // R8 edit discarded by refresh
      wr(8'hC1, 8'hAA);
      wait_refresh();
      rd(8'hC1, 8'h00, "R8 refresh discards edit");
      // R9 refresh disabled holds edit
      wr(8'h10, 8'h04);
      wr(8'hC1, 8'hAA);
      wait_refresh();
      rd(8'hC1, 8'hAA, "R9 edit held");
      rd(8'h10, 8'h04, "R9 control byte");
      // R10/R11 update command with a second command during busy
      wr(8'hC0, 8'h13);
      wr(8'h3F, 8'h11);          // command edge E
      wr(8'h3F, 8'h11);          // captured at E+2, ignored
      rd(8'h3F, 8'h01, "R10 busy set");
      repeat (BUSY - 5) @(posedge clk);
      rd(8'h3F, 8'h01, "R11 busy last cycle");
      rd(8'h3F, 8'h00, "R11 busy not extended");
      // R12 persistence seen after refresh
      wr(8'h10, 8'h00);
      wait_refresh();
      rd(8'hC0, 8'h13, "R12 power byte persisted");
      rd(8'hC1, 8'hAA, "R10 array holds mirror");
      // R11 other command value
      wr(8'h3F, 8'h22);
      rd(8'h3F, 8'h00, "R11 non-update value");
      // R6 protection disarmed
      wr(8'h10, 8'h04);
      wr(8'hCA, 8'h00);
      wr(8'h3C, 8'h00);
      wr(8'h06, 8'h77);
      rd(8'h06, 8'h77, "R6 disarmed write");
      rd(8'hC6, 8'h45, "R6 disarmed mirror read");
      rd(8'hC0, 8'h13, "R6 disarmed C0");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule